// File: doc/BRIEF.md
# Split-Count Programmable Clock Divider

This block produces a divided clock from its input clock. Each output period has a high phase and a low phase, and a separate count sets the length of each, so one 32-bit configuration word sets both the division ratio and the duty cycle. Three more controls are available. An odd-ratio adjust moves the falling output edge onto the falling edge of the input clock, which gives a near-even duty cycle for odd totals. A bypass passes the input clock straight through. A phase offset holds back the first rising output edge by a set number of input cycles.

A new word is written with a single-cycle strobe. It is held in a shadow register and becomes active only when the current low phase ends, so a reload never produces a shortened pulse. Widths of the count and offset fields, the reset settings, and whether the odd-ratio and bypass features are built at all are parameters.

Top module: `clkdiv_top`

## Requirements
- R1: With default parameters, the reset settings are high count 1, low count 1, offset 0, odd adjust off and bypass off. `div_o` is low while `rst_ni` is low. After reset is released, `div_o` rises at the first rising edge of `clk_i` and then toggles on every rising edge, which divides by 2.
- R2: The configuration word is decoded as follows: high count in bits [7:0], bypass in bit 8, phase offset in bits [15:9], low count in bits [30:23], odd adjust in bit 31. Bits [22:16] have no effect on the output.
- R3: With odd adjust and bypass off, `div_o` rises on a rising edge of `clk_i`, stays high for H input cycles, then stays low for L input cycles. The period is H+L cycles.
- R4: A high count or low count of 0 behaves exactly like a count of 1.
- R5: With odd adjust on, the high-to-low transition happens on the falling edge of `clk_i` that follows the rising edge where it would otherwise occur. The high phase is then H+½ cycles and the low phase is L−½ cycles.
- R6: With bypass on, `div_o` equals `clk_i`.
- R7: A written word has no effect until the rising edge that ends the current low phase. Until then the previous settings continue unchanged.
- R8: When a word with a nonzero offset P is applied, the next rising edge of `div_o` comes P input cycles later than it would have with offset 0. `div_o` stays low during that wait.
- R9: If more than one word is written before a period boundary, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | One-cycle write strobe for the configuration word |
| cfg_word_i | input | 32 | Configuration word (fields per R2) |
| div_o | output | 1 | Divided (or bypassed) output clock |

## Verification
The assertions assume that `cfg_we_i` and `cfg_word_i` are synchronous to the rising edge of `clk_i` and stay stable around it. They also assume that reset is released away from a rising edge, so the counter and the active settings move only at rising edges. The stimulus meets these assumptions by changing every input on falling edges. The output is sampled one nanosecond after each clock edge, which lets the half-cycle odd-ratio extension and the bypassed clock be checked in both halves of every cycle. Randomized words also fill the ignored bits [22:16] and use zero counts, so decoding and the zero-as-one rule are exercised together with back-to-back rewrites.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // Field layout of the 32-bit configuration word
   localparam int WORD_W  = 32;
   localparam int FLD_W   = 8;
   localparam int PHF_W   = 7;
   localparam int HI_LSB  = 0;
   localparam int BYP_POS = 8;
   localparam int PH_LSB  = 9;
   localparam int LO_LSB  = 23;
   localparam int ODD_POS = 31;
   localparam int GAP_LSB = PH_LSB + PHF_W;
   localparam int GAP_MSB = LO_LSB - 1;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_HIGH = 2'd1,
      ST_LOW  = 2'd2
   } dstate_e;

   typedef struct packed {
      logic             odd;
      logic             byp;
      logic [FLD_W-1:0] lo;
      logic [PHF_W-1:0] ph;
      logic [FLD_W-1:0] hi;
   } dcfg_t;

   function automatic dcfg_t unpack_cfg(input logic [WORD_W-1:0] w);
      dcfg_t c;
      c.hi  = w[HI_LSB +: FLD_W];
      c.lo  = w[LO_LSB +: FLD_W];
      c.ph  = w[PH_LSB +: PHF_W];
      c.byp = w[BYP_POS];
      c.odd = w[ODD_POS];
      return c;
   endfunction

   // A zero length is stretched to one cycle so the output never sticks
   function automatic logic [FLD_W-1:0] phase_len(input logic [FLD_W-1:0] n);
      return (n == '0) ? FLD_W'(1) : n;
   endfunction

endpackage

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow
   import clkdiv_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int PH_W   = 7,
   parameter int DEF_HI = 1,
   parameter int DEF_LO = 1,
   parameter int DEF_PH = 0,
   parameter bit ODD_EN = 1'b1,
   parameter bit BYP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              take,
   output dcfg_t             act_o,
   output dcfg_t             shd_o,
   output logic              pend_o
);

   localparam logic [FLD_W-1:0] CMASK = FLD_W'((1 << CNT_W) - 1);
   localparam logic [PHF_W-1:0] PMASK = PHF_W'((1 << PH_W) - 1);
   localparam dcfg_t RST_CFG = '{odd: 1'b0, byp: 1'b0,
                                 lo: FLD_W'(DEF_LO) & CMASK,
                                 ph: PHF_W'(DEF_PH) & PMASK,
                                 hi: FLD_W'(DEF_HI) & CMASK};

   dcfg_t raw;
   dcfg_t masked;
   logic  odd_sel;
   logic  byp_sel;
   logic  unused_gap;

   assign raw        = unpack_cfg(wr_word);
   assign unused_gap = ^wr_word[GAP_MSB:GAP_LSB];

   generate
      if (ODD_EN) begin : g_odd
         assign odd_sel = raw.odd;
      end else begin : g_no_odd
         logic unused_odd;
         assign unused_odd = raw.odd;
         assign odd_sel    = 1'b0;
      end
      if (BYP_EN) begin : g_byp
         assign byp_sel = raw.byp;
      end else begin : g_no_byp
         logic unused_byp;
         assign unused_byp = raw.byp;
         assign byp_sel    = 1'b0;
      end
   endgenerate

   always_comb begin
      masked.hi  = raw.hi & CMASK;
      masked.lo  = raw.lo & CMASK;
      masked.ph  = raw.ph & PMASK;
      masked.odd = odd_sel;
      masked.byp = byp_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o  <= RST_CFG;
         shd_o  <= RST_CFG;
         pend_o <= 1'b0;
      end else begin
         if (wr_en) shd_o <= masked;
         if (take)  act_o <= shd_o;
         if (wr_en)     pend_o <= 1'b1;
         else if (take) pend_o <= 1'b0;
      end
   end

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
   import clkdiv_pkg::*;
#(
   parameter int CW     = 8,
   parameter int DEF_PH = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  dcfg_t         act_i,
   input  dcfg_t         shd_i,
   input  logic          pend_i,
   output logic          take_o,
   output dstate_e       st_o,
   output logic [CW-1:0] cnt_o,
   output logic          hi_o
);

   dstate_e       st_n;
   logic [CW-1:0] cnt_n;
   logic          at_end;
   logic [FLD_W-1:0] nxt_hi;
   logic          unused_flds;

   assign unused_flds = ^{act_i.odd, act_i.byp, act_i.ph, shd_i.odd, shd_i.byp, shd_i.lo};

   assign at_end = (st_o == ST_LOW) && (cnt_o == '0);
   assign take_o = at_end && pend_i;
   assign nxt_hi = take_o ? shd_i.hi : act_i.hi;

   always_comb begin
      st_n  = st_o;
      cnt_n = cnt_o - CW'(1);
      unique case (st_o)
         ST_WAIT: begin
            if (cnt_o == '0) begin
               st_n  = ST_HIGH;
               cnt_n = CW'(phase_len(act_i.hi)) - CW'(1);
            end
         end
         ST_HIGH: begin
            if (cnt_o == '0) begin
               st_n  = ST_LOW;
               cnt_n = CW'(phase_len(act_i.lo)) - CW'(1);
            end
         end
         ST_LOW: begin
            if (cnt_o == '0) begin
               if (take_o && (shd_i.ph != '0)) begin
                  st_n  = ST_WAIT;
                  cnt_n = CW'(shd_i.ph) - CW'(1);
               end else begin
                  st_n  = ST_HIGH;
                  cnt_n = CW'(phase_len(nxt_hi)) - CW'(1);
               end
            end
         end
         default: begin
            st_n  = ST_WAIT;
            cnt_n = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_o  <= ST_WAIT;
         cnt_o <= CW'(DEF_PH);
         hi_o  <= 1'b0;
      end else begin
         st_o  <= st_n;
         cnt_o <= cnt_n;
         hi_o  <= (st_n == ST_HIGH);
      end
   end

endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out #(
   parameter bit ODD_EN = 1'b1,
   parameter bit BYP_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hi,
   input  logic odd,
   input  logic byp,
   output logic ext_o,
   output logic div_o
);

   logic base;

   generate
      if (ODD_EN) begin : g_ext
         // falling-edge copy keeps the output high for half an extra cycle
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) ext_o <= 1'b0;
            else        ext_o <= hi & odd;
         end
      end else begin : g_no_ext
         logic unused_odd;
         assign unused_odd = odd;
         assign ext_o      = 1'b0;
      end
   endgenerate

   assign base = hi | ext_o;

   generate
      if (BYP_EN) begin : g_mux
         assign div_o = byp ? clk : base;
      end else begin : g_direct
         logic unused_byp;
         assign unused_byp = byp;
         assign div_o      = base;
      end
   endgenerate

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
   import clkdiv_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int PH_W   = 7,
   parameter int DEF_HI = 1,
   parameter int DEF_LO = 1,
   parameter int DEF_PH = 0,
   parameter bit ODD_EN = 1'b1,
   parameter bit BYP_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [WORD_W-1:0] cfg_word_i,
   output logic              div_o
);

   localparam int CW = (CNT_W > PH_W) ? CNT_W : PH_W;

   generate
      if (CNT_W < 1 || CNT_W > FLD_W) begin : g_bad_cnt
         $error("clkdiv_top: CNT_W must lie in 1..%0d", FLD_W);
      end
      if (PH_W < 1 || PH_W > PHF_W) begin : g_bad_ph
         $error("clkdiv_top: PH_W must lie in 1..%0d", PHF_W);
      end
      if (DEF_HI < 0 || DEF_HI >= (1 << CNT_W) || DEF_LO < 0 || DEF_LO >= (1 << CNT_W)) begin : g_bad_def
         $error("clkdiv_top: reset counts do not fit CNT_W");
      end
      if (DEF_PH < 0 || DEF_PH >= (1 << PH_W)) begin : g_bad_defph
         $error("clkdiv_top: reset offset does not fit PH_W");
      end
   endgenerate

   dcfg_t         act_w;
   dcfg_t         shd_w;
   logic          pend_w;
   logic          take_w;
   dstate_e       st_w;
   logic [CW-1:0] cnt_w;
   logic          hi_w;
   logic          ext_w;

   clkdiv_shadow #(
      .CNT_W(CNT_W), .PH_W(PH_W), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO),
      .DEF_PH(DEF_PH), .ODD_EN(ODD_EN), .BYP_EN(BYP_EN)
   ) u_shadow (
      .clk(clk_i), .rst_n(rst_ni), .wr_en(cfg_we_i), .wr_word(cfg_word_i),
      .take(take_w), .act_o(act_w), .shd_o(shd_w), .pend_o(pend_w)
   );

   clkdiv_seq #(
      .CW(CW), .DEF_PH(DEF_PH)
   ) u_seq (
      .clk(clk_i), .rst_n(rst_ni), .act_i(act_w), .shd_i(shd_w),
      .pend_i(pend_w), .take_o(take_w), .st_o(st_w), .cnt_o(cnt_w), .hi_o(hi_w)
   );

   clkdiv_out #(
      .ODD_EN(ODD_EN), .BYP_EN(BYP_EN)
   ) u_out (
      .clk(clk_i), .rst_n(rst_ni), .hi(hi_w), .odd(act_w.odd),
      .byp(act_w.byp), .ext_o(ext_w), .div_o(div_o)
   );

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
   import clkdiv_pkg::*;
#(
   parameter int CW = 8
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          cfg_we_i,
   input dstate_e       st,
   input logic [CW-1:0] cnt,
   input logic          take,
   input logic          pend,
   input logic          hi_q,
   input logic          ext_q,
   input dcfg_t         act
);

   logic unused_chk;
   assign unused_chk = ^{act.ph, act.byp};

   AST_WAIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_WAIT) |-> !hi_q); // R8

   AST_HIGH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_HIGH) |-> (FLD_W'(cnt) < phase_len(act.hi))); // R3

   AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_LOW) |-> (FLD_W'(cnt) < phase_len(act.lo))); // R4

   AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take |=> $stable(act)); // R7

   AST_TAKE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take |-> pend); // R7

   AST_ODD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act.odd |-> !ext_q); // R5

   AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_i |=> pend); // R9

endmodule

bind clkdiv_top clkdiv_chk #(.CW(CW)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .st(st_w),
   .cnt(cnt_w), .take(take_w), .pend(pend_w), .hi_q(hi_w), .ext_q(ext_w),
   .act(act_w)
);

// File: tb/sim_clkdiv_top.sv
`timescale 1ns/1ps
module sim_clkdiv_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [31:0] wd = '0;
   logic        div;

   always #2.5 clk = ~clk;

   clkdiv_top u0 (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_word_i(wd), .div_o(div)
   );

   int    vecs = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string req = "R1";

   // behavioural reference: mode 0 wait, 1 high, 2 low
   int m_mode, m_cnt, m_pend, m_ext;
   int a_hi, a_lo, a_ph, a_odd, a_byp;
   int s_hi, s_lo, s_ph, s_odd, s_byp;

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic void m_reset();
      m_mode = 0; m_cnt = 0; m_pend = 0; m_ext = 0;
      a_hi = 1; a_lo = 1; a_ph = 0; a_odd = 0; a_byp = 0;
      s_hi = 1; s_lo = 1; s_ph = 0; s_odd = 0; s_byp = 0;
   endfunction

   function automatic void m_edge(bit w, logic [31:0] d);
      if (m_mode == 0) begin
         if (m_cnt == 0) begin m_mode = 1; m_cnt = eff(a_hi) - 1; end
         else m_cnt--;
      end else if (m_mode == 1) begin
         if (m_cnt == 0) begin m_mode = 2; m_cnt = eff(a_lo) - 1; end
         else m_cnt--;
      end else begin
         if (m_cnt == 0) begin
            if (m_pend != 0) begin
               a_hi = s_hi; a_lo = s_lo; a_ph = s_ph; a_odd = s_odd; a_byp = s_byp;
               m_pend = 0;
               if (a_ph > 0) begin m_mode = 0; m_cnt = a_ph - 1; end
               else begin m_mode = 1; m_cnt = eff(a_hi) - 1; end
            end else begin
               m_mode = 1; m_cnt = eff(a_hi) - 1;
            end
         end else m_cnt--;
      end
      if (w) begin
         s_hi = int'(d[7:0]); s_byp = int'(d[8]); s_ph = int'(d[15:9]);
         s_lo = int'(d[30:23]); s_odd = int'(d[31]);
         m_pend = 1;
      end
   endfunction

   task automatic compare(bit exp, string when);
      vecs++;
      if (div !== exp) begin
         bad++;
         $display("FAIL %s (%s, t=%0t): div_o=%b expected %b", req, when, $time, div, exp);
      end
   endtask

   initial m_reset();

   always @(posedge clk) begin
      #1;
      if (!rst_n) m_reset();
      else m_edge(we, wd);
      compare((a_byp != 0) ? 1'b1 : ((m_mode == 1) || (m_ext != 0)), "clock high");
   end

   always @(negedge clk) begin
      #1;
      if (!rst_n) m_reset();
      else m_ext = ((m_mode == 1) && (a_odd != 0)) ? 1 : 0;
      compare((a_byp != 0) ? 1'b0 : ((m_mode == 1) || (m_ext != 0)), "clock low");
   end

   function automatic logic [31:0] mk(int hi, int lo, int ph, bit odd, bit byp, int gap);
      logic [31:0] w;
      w = '0;
      w[7:0] = 8'(hi); w[8] = byp; w[15:9] = 7'(ph);
      w[22:16] = 7'(gap); w[30:23] = 8'(lo); w[31] = odd;
      return w;
   endfunction

   task automatic wr(logic [31:0] d);
      @(negedge clk); we = 1'b1; wd = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      req = "R1";
      idle(4);                   // div_o low during reset, compared each half cycle
      rst_n = 1'b1;
      idle(12);                  // default divide-by-2 after release
      req = "R3";  wr(mk(3, 2, 0, 0, 0, 0));    idle(30);
      req = "R2";  wr(mk(2, 4, 0, 0, 0, 7'h55)); idle(30);
      req = "R4";  wr(mk(0, 0, 0, 0, 0, 0));    idle(12);
      req = "R4";  wr(mk(0, 3, 0, 0, 0, 0));    idle(16);
      req = "R5";  wr(mk(2, 3, 0, 1, 0, 0));    idle(30);
      req = "R5";  wr(mk(1, 1, 0, 1, 0, 0));    idle(12);
      req = "R6";  wr(mk(4, 4, 0, 0, 1, 0));    idle(20);
      req = "R7";  wr(mk(8, 8, 0, 0, 0, 0));    idle(3);
      req = "R7";  wr(mk(1, 2, 0, 0, 0, 0));    idle(40);
      req = "R8";  wr(mk(1, 4, 5, 0, 0, 0));    idle(30);
      req = "R8";  wr(mk(2, 2, 3, 1, 0, 0));    idle(30);
      req = "R9";  wr(mk(5, 5, 0, 0, 0, 0));    wr(mk(2, 1, 0, 0, 0, 0)); idle(30);
      req = "R1";
      @(negedge clk); rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(12);
      req = "R2";
      for (int i = 0; i < 60; i++) begin
         wr(mk(int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
               int'($urandom_range(0, 4)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 3) == 0), int'($urandom_range(0, 127))));
         idle(int'($urandom_range(0, 20)));
      end
      idle(20);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not finish (actual hung, expected done)");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

endmodule